// File: doc/BRIEF.md
# Reversible Toffoli Cascade Evaluator

This block runs a stored list of multiple-control Toffoli gates over a small register of classical bit lines. The register holds the read-only input lines, the output lines and an optional ancilla line. Software or a neighbouring block first fills the gate store through a write port. Each entry holds a ternary polarity code for every line slot and a mask of the lines that the gate inverts. A start pulse captures the input word and clears the outputs and the ancilla. The block then applies one gate per clock cycle, either from the first entry upward or from the last entry downward. At the end it raises `done` and shows the final line vector.

A row of a lookup table maps onto one entry. The bits of the row's input value give the polarity of each input control. The set bits of the row's output value become the target mask. Because every gate undoes itself, repeating a gate clears whatever it set. Repeating the gate that computed the ancilla therefore returns the ancilla to zero.

Top module: `toffoli_cascade`

## Requirements
- R1: Line index i in `lines_out` carries input bit i for i < K_IN. Indices K_IN to K_IN+M_OUT-1 are the outputs, and index K_IN+M_OUT is the ancilla when HAS_ANC is 1. A start accepted while not busy captures `x_in` into the input lines and clears every output and ancilla line.
- R2: The control code of slot s sits in `wr_ctl[2s+1:2s]`. Code 1 is active when the line is 1, code 0 is active when the line is 0, and code 2 places no condition on that line.
- R3: If every control of a gate is active, each line whose bit is set in `wr_tgt` (bit s for slot s) is inverted. Otherwise no line changes. A gate with code 2 in every slot always fires, and a single code 1 control with one target copies a line by XOR.
- R4: With `reverse` at 0, entries 0 to N-1 are applied in order, one per clock edge after the edge that samples start, where N is the effective count. `done` is high after edge N and `busy` is high only while gates remain.
- R5: With `reverse` at 1, entries N-1 down to 0 are applied in that order.
- R6: A count of 0 finishes after the start edge with the freshly loaded vector. A `gate_count` above DEPTH is treated as DEPTH.
- R7: A gate is illegal if any slot holds code 3, if a slot at or above the line count has a code other than 2 or a target bit set, if it targets an input line, or if it targets a line it also controls. Reaching an illegal gate as the j-th executed gate (j from 0) ends the run after edge j+1. The run then ends with `err` high and `done` high, the output and ancilla lines back at zero, and the input lines kept.
- R8: The input lines never change while a run is in progress.
- R9: `done`, `err` and `lines_out` hold until the next accepted start, and that start clears `err`.
- R10: While busy, both a start pulse and a gate write are ignored.
- R11: After reset the block is idle, `done` and `err` are low and every line reads 0.
- R12: Applying a gate twice restores its targets, so repeating the gate that set the ancilla returns the ancilla to 0 at the end of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write one gate entry |
| wr_addr | input | $clog2(DEPTH) | Entry index to write |
| wr_ctl | input | 2*SLOTS | Two-bit polarity code per line slot |
| wr_tgt | input | SLOTS | Target mask, one bit per line slot |
| gate_count | input | $clog2(DEPTH)+1 | Number of entries to run, sampled at start |
| reverse | input | 1 | Run from the last entry down, sampled at start |
| start | input | 1 | Begin a run |
| x_in | input | K_IN | Input word, sampled at start |
| busy | output | 1 | Gates still being applied |
| done | output | 1 | Run finished, results valid |
| err | output | 1 | Run stopped on an illegal gate |
| lines_out | output | K_IN+M_OUT+HAS_ANC | Current line vector |

## Verification
The assertions assume that reset is applied before the first start. They also assume that `start`, `x_in` and the write port change only away from the clock edge, so each value is sampled whole. The bench drives every input on the falling edge. It waits for each run to report `done` before it loads new entries or launches the next run. It pulses start and write while busy only when the remaining gates far outnumber the cycles that the pulse lasts.

// File: rtl/tcasc_pkg.sv
package tcasc_pkg;

    typedef enum logic [1:0] {
        CTL_NEG = 2'd0,
        CTL_POS = 2'd1,
        CTL_ANY = 2'd2,
        CTL_BAD = 2'd3
    } ctl_code_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;

endpackage

// File: rtl/tcasc_store.sv
module tcasc_store #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/tcasc_gate.sv
module tcasc_gate #(
    parameter int NLINES = 11,
    parameter int NIN    = 5,
    parameter int SLOTS  = 16
) (
    input  logic [NLINES-1:0]  lines_i,
    input  logic [2*SLOTS-1:0] ctl_i,
    input  logic [SLOTS-1:0]   tgt_i,
    output logic [NLINES-1:0]  lines_o,
    output logic               bad_o
);

    logic [SLOTS-1:0] act;
    logic [SLOTS-1:0] bad;
    logic             fire;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        tcasc_pkg::ctl_code_e code;
        assign code = tcasc_pkg::ctl_code_e'(ctl_i[2*s+1:2*s]);
        if (s < NLINES) begin : g_live
            localparam bit IS_INPUT = (s < NIN);
            assign act[s] = (code == tcasc_pkg::CTL_ANY)
                          | ((code == tcasc_pkg::CTL_POS) &  lines_i[s])
                          | ((code == tcasc_pkg::CTL_NEG) & ~lines_i[s]);
            assign bad[s] = (code == tcasc_pkg::CTL_BAD)
                          | (tgt_i[s] & (code != tcasc_pkg::CTL_ANY))
                          | (tgt_i[s] & IS_INPUT);
        end else begin : g_spare
            assign act[s] = 1'b1;
            assign bad[s] = (code != tcasc_pkg::CTL_ANY) | tgt_i[s];
        end
    end

    assign fire    = &act;
    assign bad_o   = |bad;
    assign lines_o = lines_i ^ ({NLINES{fire}} & tgt_i[NLINES-1:0]);

endmodule

// File: rtl/toffoli_cascade.sv
module toffoli_cascade #(
    parameter int K_IN    = 5,
    parameter int M_OUT   = 5,
    parameter int HAS_ANC = 1,
    parameter int SLOTS   = 16,
    parameter int DEPTH   = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [$clog2(DEPTH)-1:0]       wr_addr,
    input  logic [2*SLOTS-1:0]             wr_ctl,
    input  logic [SLOTS-1:0]               wr_tgt,
    input  logic [$clog2(DEPTH):0]         gate_count,
    input  logic                           reverse,
    input  logic                           start,
    input  logic [K_IN-1:0]                x_in,
    output logic                           busy,
    output logic                           done,
    output logic                           err,
    output logic [K_IN+M_OUT+HAS_ANC-1:0]  lines_out
);

    localparam int NLINES = K_IN + M_OUT + HAS_ANC;
    localparam int NUPPER = NLINES - K_IN;
    localparam int AW     = $clog2(DEPTH);
    localparam int CW     = AW + 1;
    localparam int GW     = 3 * SLOTS;

    typedef struct packed {
        tcasc_pkg::phase_e ph;
        logic [NLINES-1:0] lines;
        logic [AW-1:0]     ptr;
        logic [CW-1:0]     left;
        logic              rev;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    logic [GW-1:0]        rd_word;
    logic [NLINES-1:0]    gate_lines;
    logic                 gate_bad;
    logic [CW-1:0]        cnt_eff;
    logic                 wr_ok;

    assign wr_ok = wr_en && (st_q.ph != tcasc_pkg::PH_RUN);

    tcasc_store #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .WIDTH (GW)
    ) u_store (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (wr_addr),
        .wdata ({wr_tgt, wr_ctl}),
        .raddr (st_q.ptr),
        .rdata (rd_word)
    );

    tcasc_gate #(
        .NLINES (NLINES),
        .NIN    (K_IN),
        .SLOTS  (SLOTS)
    ) u_gate (
        .lines_i (st_q.lines),
        .ctl_i   (rd_word[2*SLOTS-1:0]),
        .tgt_i   (rd_word[GW-1:2*SLOTS]),
        .lines_o (gate_lines),
        .bad_o   (gate_bad)
    );

    assign cnt_eff = (gate_count > CW'(DEPTH)) ? CW'(DEPTH) : gate_count;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            tcasc_pkg::PH_RUN: begin
                if (gate_bad) begin
                    st_d.lines = {NUPPER'(0), st_q.lines[K_IN-1:0]};
                    st_d.err   = 1'b1;
                    st_d.ph    = tcasc_pkg::PH_FIN;
                end else begin
                    st_d.lines = gate_lines;
                    st_d.left  = st_q.left - CW'(1);
                    st_d.ptr   = st_q.rev ? (st_q.ptr - AW'(1)) : (st_q.ptr + AW'(1));
                    if (st_q.left == CW'(1)) begin
                        st_d.ph = tcasc_pkg::PH_FIN;
                    end
                end
            end
            default: begin
                if (start) begin
                    st_d.lines = {NUPPER'(0), x_in};
                    st_d.err   = 1'b0;
                    st_d.rev   = reverse;
                    st_d.left  = cnt_eff;
                    st_d.ptr   = reverse ? AW'(cnt_eff - CW'(1)) : '0;
                    st_d.ph    = (cnt_eff == '0) ? tcasc_pkg::PH_FIN : tcasc_pkg::PH_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.ph == tcasc_pkg::PH_RUN);
    assign done      = (st_q.ph == tcasc_pkg::PH_FIN);
    assign err       = st_q.err;
    assign lines_out = st_q.lines;

endmodule

// File: rtl/toffoli_cascade_chk.sv
module toffoli_cascade_chk #(
    parameter int K_IN    = 5,
    parameter int M_OUT   = 5,
    parameter int HAS_ANC = 1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start,
    input logic [K_IN-1:0]               x_in,
    input logic                          busy,
    input logic                          done,
    input logic                          err,
    input logic [K_IN+M_OUT+HAS_ANC-1:0] lines_out
);

    localparam int NL = K_IN + M_OUT + HAS_ANC;

    // R1: an accepted start loads the input word into the input lines
    p_load_inputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (lines_out[K_IN-1:0] == $past(x_in)));

    // R4: running and finished never overlap
    p_busy_not_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R4: a run only begins from an accepted start
    p_run_needs_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8: input lines stay fixed across every gate step
    p_inputs_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(lines_out[K_IN-1:0]));

    // R7: an aborted run reports done with cleared outputs and ancilla
    p_abort_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && (lines_out[NL-1:K_IN] == '0)));

    // R9: results hold while no new start arrives
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(lines_out) && $stable(err)));

endmodule

bind toffoli_cascade toffoli_cascade_chk #(
    .K_IN    (K_IN),
    .M_OUT   (M_OUT),
    .HAS_ANC (HAS_ANC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .x_in      (x_in),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .lines_out (lines_out)
);

// File: tb/toffoli_cascade_test.sv
`timescale 1ns/1ps
module toffoli_cascade_test;

    localparam int K  = 5;
    localparam int M  = 5;
    localparam int A  = 1;
    localparam int SL = 16;
    localparam int D  = 64;
    localparam int AW = 6;
    localparam int CW = 7;
    localparam int NL = K + M + A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [2*SL-1:0] wr_ctl = '0;
    logic [SL-1:0] wr_tgt = '0;
    logic [CW-1:0] gate_count = '0;
    logic          reverse = 1'b0;
    logic          start = 1'b0;
    logic [K-1:0]  x_in = '0;
    logic          busy, done, err;
    logic [NL-1:0] lines_out;

    always #2 clk = ~clk;

    toffoli_cascade #(.K_IN(K), .M_OUT(M), .HAS_ANC(A), .SLOTS(SL), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_ctl(wr_ctl), .wr_tgt(wr_tgt), .gate_count(gate_count),
        .reverse(reverse), .start(start), .x_in(x_in),
        .busy(busy), .done(done), .err(err), .lines_out(lines_out)
    );

    logic [2*SL-1:0] m_ctl [D];
    logic [SL-1:0]   m_tgt [D];

    typedef struct {
        logic [NL-1:0] lines;
        logic          err;
        int            lat;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   pending = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic [2*SL-1:0] ctl_none();
        return {SL{2'b10}};
    endfunction

    function automatic logic [2*SL-1:0] ctl_set(input logic [2*SL-1:0] v, input int slot, input logic [1:0] code);
        logic [2*SL-1:0] r;
        r = v;
        r[2*slot +: 2] = code;
        return r;
    endfunction

    task automatic put_gate(input int addr, input logic [2*SL-1:0] c, input logic [SL-1:0] t);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_ctl = c; wr_tgt = t;
        @(negedge clk);
        wr_en = 1'b0;
        m_ctl[addr] = c;
        m_tgt[addr] = t;
    endtask

    // lookup row: input value sets control polarity, output value sets targets
    task automatic put_row(input int addr, input int xv, input int yv);
        logic [2*SL-1:0] c;
        c = ctl_none();
        for (int i = 0; i < K; i++) c = ctl_set(c, i, ((xv >> i) & 1) != 0 ? 2'd1 : 2'd0);
        put_gate(addr, c, SL'(yv) << K);
    endtask

    task automatic model(input logic [K-1:0] x, input int cnt, input bit rev,
                         output logic [NL-1:0] ln, output logic e, output int lat);
        int c;
        ln = {{(NL-K){1'b0}}, x};
        e = 1'b0;
        c = (cnt > D) ? D : cnt;
        lat = c + 1;
        for (int i = 0; i < c; i++) begin
            int idx;
            bit bad, fire;
            logic [2*SL-1:0] cc;
            logic [SL-1:0] tt;
            idx = rev ? (c - 1 - i) : i;
            cc = m_ctl[idx]; tt = m_tgt[idx];
            bad = 1'b0; fire = 1'b1;
            for (int s = 0; s < SL; s++) begin
                logic [1:0] code;
                code = cc[2*s +: 2];
                if (s < NL) begin
                    if (code == 2'd3) bad = 1'b1;
                    if (tt[s] && code != 2'd2) bad = 1'b1;
                    if (tt[s] && s < K) bad = 1'b1;
                    if (code == 2'd0 && ln[s]) fire = 1'b0;
                    if (code == 2'd1 && !ln[s]) fire = 1'b0;
                end else if (code != 2'd2 || tt[s]) begin
                    bad = 1'b1;
                end
            end
            if (bad) begin
                ln[NL-1:K] = '0;
                e = 1'b1;
                lat = i + 2;
                break;
            end
            if (fire) ln = ln ^ tt[NL-1:0];
        end
    endtask

    task automatic run(input logic [K-1:0] x, input int cnt, input bit rev, input string tag, input bit disturb);
        exp_t ex;
        model(x, cnt, rev, ex.lines, ex.err, ex.lat);
        ex.tag = tag;
        exp_q.push_back(ex);
        @(negedge clk);
        x_in = x; gate_count = CW'(cnt); reverse = rev; start = 1'b1;
        pending = 1'b1;
        @(negedge clk);
        if (disturb) begin
            x_in = ~x; reverse = ~rev;
            wr_en = 1'b1; wr_addr = '0; wr_ctl = ctl_none(); wr_tgt = SL'({M{1'b1}}) << K;
            @(negedge clk);
            wr_en = 1'b0;
        end
        start = 1'b0;
        wait (!pending);
    endtask

    // monitor: pops the expected item and compares at the first done
    initial begin
        forever begin
            exp_t ex;
            int lat;
            wait (pending);
            @(negedge clk);
            lat = 1;
            while (!done) begin
                @(negedge clk);
                lat++;
            end
            ex = exp_q.pop_front();
            check(lines_out == ex.lines, {ex.tag, " lines"}, 32'(lines_out), 32'(ex.lines));
            check(err == ex.err, {ex.tag, " err"}, 32'(err), 32'(ex.err));
            check(lat == ex.lat, {ex.tag, " latency"}, 32'(lat), 32'(ex.lat));
            pending = 1'b0;
        end
    end

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [2*SL-1:0] c;
        logic [NL-1:0]   held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(!busy && !done && !err, "R11 idle flags", {29'd0, busy, done, err}, 32'd0);
        check(lines_out == '0, "R11 lines", 32'(lines_out), 32'd0);

        // R1 R2 R3 R4: lookup rows, one entry per row
        put_row(0, 16, 7);
        put_row(1, 7, 16);
        put_row(2, 8, 17);
        put_row(3, 9, 15);
        run(5'd16, 4, 1'b0, "R1 R2 R4 row 16", 1'b0);
        run(5'd7,  4, 1'b0, "R2 R3 row 7", 1'b0);
        run(5'd9,  4, 1'b0, "R3 R4 row 9", 1'b0);
        run(5'd3,  4, 1'b0, "R3 no row", 1'b0);

        // R9 results hold after done
        held = lines_out;
        repeat (4) @(negedge clk);
        check(done && lines_out == held, "R9 hold", 32'(lines_out), 32'(held));

        // R3 unconditional gate and CNOT copy
        put_gate(0, ctl_none(), SL'((1 << 9) | (1 << 10)));
        put_gate(1, ctl_set(ctl_none(), 0, 2'd1), SL'(1 << 5));
        run(5'd1, 2, 1'b0, "R3 uncond cnot x1", 1'b0);
        run(5'd0, 2, 1'b0, "R3 uncond cnot x0", 1'b0);

        // R12 ancilla compute, use, uncompute
        c = ctl_set(ctl_set(ctl_none(), 0, 2'd1), 1, 2'd1);
        put_gate(0, c, SL'(1 << 10));
        put_gate(1, ctl_set(ctl_set(ctl_none(), 10, 2'd1), 2, 2'd1), SL'(1 << 5));
        put_gate(2, ctl_set(ctl_set(ctl_none(), 10, 2'd1), 3, 2'd0), SL'(1 << 6));
        put_gate(3, c, SL'(1 << 10));
        run(5'b00111, 4, 1'b0, "R12 anc uncompute a", 1'b0);
        run(5'b01011, 4, 1'b0, "R12 anc uncompute b", 1'b0);
        run(5'b00011, 3, 1'b0, "R12 anc left set", 1'b0);

        // R5 order dependence
        put_gate(0, ctl_none(), SL'(1 << 5));
        put_gate(1, ctl_set(ctl_none(), 5, 2'd1), SL'(1 << 6));
        run(5'd4, 2, 1'b0, "R4 forward order", 1'b0);
        run(5'd4, 2, 1'b1, "R5 reverse order", 1'b0);

        // R7 illegal gates of each kind
        put_gate(0, ctl_none(), SL'(1 << 5));
        put_gate(2, ctl_none(), SL'(1 << 6));
        put_gate(1, ctl_set(ctl_none(), 0, 2'd3), SL'(1 << 7));
        run(5'd5, 3, 1'b0, "R7 code3", 1'b0);
        run(5'd5, 3, 1'b1, "R7 code3 reverse", 1'b0);
        put_gate(1, ctl_set(ctl_none(), 12, 2'd1), SL'(1 << 7));
        run(5'd6, 3, 1'b0, "R7 spare control", 1'b0);
        put_gate(1, ctl_none(), SL'(1 << 13));
        run(5'd6, 3, 1'b0, "R7 spare target", 1'b0);
        put_gate(1, ctl_none(), SL'(1 << 2));
        run(5'd6, 3, 1'b0, "R7 input target", 1'b0);
        put_gate(1, ctl_set(ctl_none(), 7, 2'd1), SL'(1 << 7));
        run(5'd6, 3, 1'b0, "R7 self control", 1'b0);
        put_gate(1, ctl_none(), SL'(1 << 7));
        run(5'd6, 3, 1'b0, "R9 err cleared", 1'b0);

        // R6 zero count and clamp
        run(5'd21, 0, 1'b0, "R6 zero count", 1'b0);
        for (int i = 0; i < D; i++) put_gate(i, ctl_none(), SL'(1) << (K + (i % (M + A))));
        run(5'd10, 64, 1'b0, "R4 full store", 1'b0);
        run(5'd10, 100, 1'b1, "R6 clamp", 1'b0);
        run(5'd10, 65, 1'b0, "R6 clamp 65", 1'b0);

        // R10 start and write ignored while busy
        run(5'd12, 20, 1'b0, "R10 busy start", 1'b1);
        run(5'd12, 20, 1'b0, "R10 busy write", 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule